// File: doc/BRIEF.md
# Error Capture and Interrupt Pulser

This block gathers the error conditions seen by a DMA transfer controller and reports each error episode to the CPU with one interrupt pulse. On every cycle it watches a read-status word and a write-status word returned by the bus. A nonzero word is a bus error. It also watches a transfer-request error strobe and a register-address error strobe. Each condition sets a sticky bit in the status register, whether or not that bit is enabled. Software reads the status register and clears bits by writing ones to the clear register.

For the first bus error of an episode, the block keeps the offending status code and its origin (write side or read side) in a details register. That register keeps its value until software clears the bus-error bit. An enable register masks which latched bits count toward the interrupt. A three-state machine controls the pulse. In `IDLE`, no enabled bit is latched. When an enabled bit appears, the machine takes the transition *arm* to `FIRE`. `FIRE` drives the interrupt high for one cycle. It then takes *hold* to `HELD` if an enabled bit is still latched, or *drop* back to `IDLE` if none is. In `HELD` it waits for software. A write to the evaluate register takes *refire* back to `FIRE`. Clearing every enabled bit takes *release* to `IDLE`.

Top module: `dma_err_capture`

## Requirements
- R1: Status bit 0 records a bus error (either status word nonzero), bit 2 records a transfer-request error, and bit 3 records a register-address error. Bits are recorded whatever the enable register holds, and bit 1 always reads 0. The status register is visible one cycle after the error.
- R2: Writing 1 to a bit of the clear register (address 2) clears that status bit. Writing 0 leaves the bit unchanged.
- R3: An error that arrives in the same cycle as a clear of its own bit leaves the bit set.
- R4: The details register (address 4) keeps the first bus error of an episode. Later bus errors set only status bit 0 and leave the details unchanged.
- R5: The details register reads {source, code}. Bits 3:0 hold the nonzero status code, and bit 4 is 1 for the write side and 0 for the read side. When only one status word is nonzero, that word is captured.
- R6: When both status words are nonzero in the same cycle, the write-side word is captured with bit 4 set.
- R7: Clearing status bit 0 also clears the details register to 0 and re-arms it, so the next bus error is captured.
- R8: The interrupt is high for exactly one cycle. The pulse appears in the second cycle after the edge at which the set of enabled, latched errors becomes non-empty.
- R9: No further pulse occurs while any enabled error stays latched, even when new errors arrive.
- R10: A write to the evaluate register (address 3) gives one pulse if an enabled error is latched. If none is latched, the write gives no pulse.
- R11: Enabling an error that is already latched, while no other enabled error is pending, gives one pulse.
- R12: Latched errors whose enable bits (address 1) are 0 give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stat | input | 4 | Read status from the bus; nonzero means error |
| wr_stat | input | 4 | Write status from the bus; nonzero means error |
| tr_err | input | 1 | Transfer-request error strobe |
| ra_err | input | 1 | Register-address error strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 status, 1 enable, 2 clear, 3 evaluate, 4 details) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on reg_addr |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
Two pairs of functions can meet in one cycle. The first is a clear write and a new error on the same status bit. The second is a read-side and a write-side bus error arriving together, which compete for the details register. The bench drives the clear write and the transfer-request strobe on the same clock edge, and expects the bit to stay set. It drives two nonzero status words at once, and expects the write word with the source flag set. It also clears the bus bit while another enabled error is still pending, and expects the details register to be re-armed without a new pulse.

// File: rtl/err_cap_pkg.sv
package err_cap_pkg;
    localparam int unsigned CODE_W = 4;
    localparam int unsigned STAT_W = 4;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;

    localparam int unsigned BIT_BUS = 0;
    localparam int unsigned BIT_TR  = 2;
    localparam int unsigned BIT_RA  = 3;
    localparam logic [STAT_W-1:0] LIVE_MASK = 4'b1101;

    localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_EVAL = 3'd3;
    localparam logic [ADDR_W-1:0] A_DET  = 3'd4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FIRE = 2'd1,
        S_HELD = 2'd2
    } pulse_state_t;

    typedef struct packed {
        logic              from_wr;
        logic [CODE_W-1:0] code;
    } detail_t;
endpackage

// File: rtl/err_status_bank.sv
module err_status_bank
    import err_cap_pkg::*;
#(
    parameter int unsigned N_BITS = STAT_W,
    parameter logic [N_BITS-1:0] MASK = LIVE_MASK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_BITS-1:0] set_i,
    input  logic              clr_we,
    input  logic [N_BITS-1:0] clr_bits,
    input  logic              en_we,
    input  logic [N_BITS-1:0] en_bits,
    output logic [N_BITS-1:0] status_o,
    output logic [N_BITS-1:0] enable_o,
    output logic              pend_o
);
    logic [N_BITS-1:0] stat_q;
    logic [N_BITS-1:0] en_q;

    for (genvar b = 0; b < N_BITS; b++) begin : g_bit
        if (MASK[b]) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stat_q[b] <= 1'b0;
                    en_q[b]   <= 1'b0;
                end else begin
                    if (set_i[b])
                        stat_q[b] <= 1'b1;
                    else if (clr_we && clr_bits[b])
                        stat_q[b] <= 1'b0;
                    if (en_we)
                        en_q[b] <= en_bits[b];
                end
            end

            AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[b] |=> stat_q[b]); // R3

            AST_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(stat_q[b]) |-> $past(clr_we && clr_bits[b])); // R2
        end else begin : g_dead
            assign stat_q[b] = 1'b0;
            assign en_q[b]   = 1'b0;
        end
    end

    assign status_o = stat_q;
    assign enable_o = en_q;
    assign pend_o   = |(stat_q & en_q);
endmodule

// File: rtl/err_detail_latch.sv
module err_detail_latch
    import err_cap_pkg::*;
#(
    parameter int unsigned W = CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rd_stat,
    input  logic [W-1:0] wr_stat,
    input  logic         rearm_i,
    output logic         bus_err_o,
    output logic         from_wr_o,
    output logic [W-1:0] code_o
);
    logic         held_q;
    logic         from_wr_q;
    logic [W-1:0] code_q;
    logic         wr_bad;
    logic         rd_bad;
    logic         take;

    assign wr_bad    = |wr_stat;
    assign rd_bad    = |rd_stat;
    assign bus_err_o = wr_bad | rd_bad;
    assign take      = bus_err_o && (!held_q || rearm_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q    <= 1'b0;
            from_wr_q <= 1'b0;
            code_q    <= '0;
        end else if (take) begin
            held_q    <= 1'b1;
            from_wr_q <= wr_bad;
            code_q    <= wr_bad ? wr_stat : rd_stat;
        end else if (rearm_i) begin
            held_q    <= 1'b0;
            from_wr_q <= 1'b0;
            code_q    <= '0;
        end
    end

    assign from_wr_o = from_wr_q;
    assign code_o    = code_q;

    AST_DETAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !rearm_i) |=> ($stable(code_q) && $stable(from_wr_q))); // R4

    AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take && wr_bad && rd_bad) |=> from_wr_q); // R6
endmodule

// File: rtl/err_irq_fsm.sv
module err_irq_fsm
    import err_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_i,
    input  logic eval_i,
    output logic irq_o
);
    pulse_state_t state_q;
    pulse_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (pend_i) state_d = S_FIRE;
            S_FIRE: state_d = pend_i ? S_HELD : S_IDLE;
            S_HELD: begin
                if (!pend_i)
                    state_d = S_IDLE;
                else if (eval_i)
                    state_d = S_FIRE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            S_FIRE:  irq_o = 1'b1;
            S_IDLE,
            S_HELD:  irq_o = 1'b0;
            default: irq_o = 1'b0;
        endcase
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R8

    AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(pend_i)); // R8

    AST_NO_REPULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HELD && !eval_i) |=> !irq_o); // R9
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
    import err_cap_pkg::*;
#(
    parameter int unsigned CW = CODE_W,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] rd_stat,
    input  logic [CW-1:0] wr_stat,
    input  logic          tr_err,
    input  logic          ra_err,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq
);
    localparam int unsigned SW = STAT_W;

    logic          bus_err;
    logic          det_wr;
    logic [CW-1:0] det_code;
    logic [SW-1:0] set_vec;
    logic [SW-1:0] status;
    logic [SW-1:0] enable;
    logic          pend;
    logic          clr_we;
    logic          en_we;
    logic          eval_we;

    assign clr_we  = reg_wr && (reg_addr == A_CLR);
    assign en_we   = reg_wr && (reg_addr == A_EN);
    assign eval_we = reg_wr && (reg_addr == A_EVAL);

    always_comb begin
        set_vec         = '0;
        set_vec[BIT_BUS] = bus_err;
        set_vec[BIT_TR]  = tr_err;
        set_vec[BIT_RA]  = ra_err;
    end

    err_detail_latch #(.W(CW)) u_detail (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stat   (rd_stat),
        .wr_stat   (wr_stat),
        .rearm_i   (clr_we && reg_wdata[BIT_BUS]),
        .bus_err_o (bus_err),
        .from_wr_o (det_wr),
        .code_o    (det_code)
    );

    err_status_bank #(.N_BITS(SW), .MASK(LIVE_MASK)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec),
        .clr_we   (clr_we),
        .clr_bits (reg_wdata[SW-1:0]),
        .en_we    (en_we),
        .en_bits  (reg_wdata[SW-1:0]),
        .status_o (status),
        .enable_o (enable),
        .pend_o   (pend)
    );

    err_irq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend),
        .eval_i (eval_we),
        .irq_o  (irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STAT:  reg_rdata[SW-1:0] = status;
            A_EN:    reg_rdata[SW-1:0] = enable;
            A_DET:   reg_rdata[CW:0]   = {det_wr, det_code};
            default: reg_rdata = '0;
        endcase
    end

    AST_DETAIL_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[BIT_BUS]) |-> (det_code == '0 && !det_wr)); // R7

    AST_BUS_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> status[BIT_BUS]); // R1
endmodule

// File: tb/test_dma_err_capture.sv
module test_dma_err_capture;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rd_stat = '0;
    logic [3:0] wr_stat = '0;
    logic       tr_err = 1'b0;
    logic       ra_err = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_err_capture i_dma_err_capture (
        .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .wr_stat(wr_stat),
        .tr_err(tr_err), .ra_err(ra_err), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic inject(input logic [3:0] r, input logic [3:0] w, input logic t, input logic m);
        rd_stat = r; wr_stat = w; tr_err = t; ra_err = m;
        @(negedge clk);
        rd_stat = '0; wr_stat = '0; tr_err = 1'b0; ra_err = 1'b0;
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = int'(irq);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt += int'(irq);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check(irq == 1'b0, "R8 reset irq", irq, 0);
        rd_reg(3'd0, d); check(d == 8'h00, "R1 reset status", d, 0);
        rd_reg(3'd4, d); check(d == 8'h00, "R7 reset details", d, 0);
    endtask

    task automatic t_masked_then_enable;
        logic [7:0] d; int c;
        wr_reg(3'd1, 8'h00);
        inject(4'h0, 4'h0, 1'b1, 1'b0);
        rd_reg(3'd0, d); check(d == 8'h04, "R1 disabled tr err recorded", d, 8'h04);
        count_pulses(4, c); check(c == 0, "R12 disabled no pulse", c, 0);
        wr_reg(3'd1, 8'h04);
        count_pulses(4, c); check(c == 1, "R11 enable latched pulses", c, 1);
        wr_reg(3'd2, 8'h00);
        rd_reg(3'd0, d); check(d == 8'h04, "R2 write 0 no effect", d, 8'h04);
        wr_reg(3'd2, 8'h04);
        rd_reg(3'd0, d); check(d == 8'h00, "R2 write 1 clears", d, 0);
        wr_reg(3'd2, 8'h02);
        rd_reg(3'd0, d); check(d == 8'h00, "R1 bit1 reads 0", d, 0);
    endtask

    task automatic t_bus_details;
        logic [7:0] d; int c;
        wr_reg(3'd1, 8'h0D);
        inject(4'h5, 4'h0, 1'b0, 1'b0);
        check(irq == 1'b0, "R8 no pulse first cycle", irq, 0);
        @(negedge clk);
        check(irq == 1'b1, "R8 pulse second cycle", irq, 1);
        @(negedge clk);
        check(irq == 1'b0, "R8 pulse one cycle", irq, 0);
        rd_reg(3'd4, d); check(d == 8'h05, "R5 read side captured", d, 8'h05);
        inject(4'h0, 4'h3, 1'b0, 1'b0);
        count_pulses(4, c); check(c == 0, "R9 no repulse bus", c, 0);
        rd_reg(3'd4, d); check(d == 8'h05, "R4 details kept", d, 8'h05);
        inject(4'h0, 4'h0, 1'b0, 1'b1);
        count_pulses(4, c); check(c == 0, "R9 no repulse ra err", c, 0);
        rd_reg(3'd0, d); check(d == 8'h09, "R1 ra err recorded", d, 8'h09);
        wr_reg(3'd2, 8'h01);
        rd_reg(3'd4, d); check(d == 8'h00, "R7 details cleared", d, 0);
        inject(4'h2, 4'h7, 1'b0, 1'b0);
        rd_reg(3'd4, d); check(d == 8'h17, "R6 write preferred", d, 8'h17);
        count_pulses(3, c); check(c == 0, "R9 still pending no pulse", c, 0);
        wr_reg(3'd2, 8'h0D);
        rd_reg(3'd0, d); check(d == 8'h00, "R2 all cleared", d, 0);
        inject(4'h0, 4'h9, 1'b0, 1'b0);
        rd_reg(3'd4, d); check(d == 8'h19, "R7 rearmed write only", d, 8'h19);
        count_pulses(4, c); check(c == 1, "R8 new episode pulse", c, 1);
        wr_reg(3'd2, 8'h01);
        wr_reg(3'd3, 8'h00);
        count_pulses(4, c); check(c == 0, "R10 eval with nothing set", c, 0);
    endtask

    task automatic t_eval_and_race;
        logic [7:0] d; int c;
        inject(4'h0, 4'h0, 1'b1, 1'b0);
        count_pulses(4, c); check(c == 1, "R8 tr err pulse", c, 1);
        wr_reg(3'd3, 8'h00);
        count_pulses(4, c); check(c == 1, "R10 eval repulses", c, 1);
        tr_err = 1'b1;
        wr_reg(3'd2, 8'h04);
        tr_err = 1'b0;
        rd_reg(3'd0, d); check(d == 8'h04, "R3 set beats clear", d, 8'h04);
        count_pulses(3, c); check(c == 0, "R9 race no pulse", c, 0);
        wr_reg(3'd2, 8'h0D);
        rd_reg(3'd0, d); check(d == 8'h00, "R2 final clear", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked_then_enable();
        t_bus_details();
        t_eval_and_race();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule